// File: doc/BRIEF.md
# TLB Fault Exception Entry Controller

This block carries out the entry into the exception handler when the address translation hardware reports a fault. The fault may be a refill miss, a hit on an invalid entry, or a store to a clean page. It receives a single-cycle strobe for each fault kind, along with:

- the store qualifier;
- the virtual address that faulted;
- the current address-space identifier;
- the exception-level bit of the status register;
- the exception base;
- the PC of the faulting instruction.

One clock edge after a strobe, the block has done all of the following:

- loaded the fault address register, the translation high register and the page-table context register;
- chosen the cause code;
- saved the return PC when that is required;
- raised its exception-level view;
- presented the handler address together with a one-cycle redirect pulse.

The handler address depends on the exception-level bit as it was in the cycle of the fault, before the block raises it. A refill taken while the processor is not already handling an exception goes to its own fast vector. Every other case uses the general vector.

Top module: `tlb_exc_entry`

## Requirements
- R1: While rst_n is low, and after it until the first fault, every output is zero.
- R2: After a fault, badvaddr_o holds the faulting address.
- R3: After a fault, entryhi_o holds fault address bits 31:13 in bits 31:13, the ASID in bits 7:0, and zero in bits 12:8.
- R4: After a fault, context_o holds fault address bits 31:13 in bits 22:4, and every other bit is zero.
- R5: A refill or invalid fault sets exccode_o to 3 when store_i is 1 and to 2 when it is 0.
- R6: A modified fault sets exccode_o to 1, whatever the value of store_i.
- R7: A refill fault redirects to ebase_i when exl_i was 0 in the fault cycle. It redirects to ebase_i + 0x180 when exl_i was 1.
- R8: Invalid and modified faults always redirect to ebase_i + 0x180.
- R9: epc_o takes pc_i on a fault when exl_i was 0, and keeps its value when exl_i was 1.
- R10: redirect_valid_o is 1 for exactly the one cycle after a fault strobe, and exl_o is 1 in that cycle. In every other cycle, exl_o equals exl_i of the previous cycle.
- R11: When several strobes are high at once, refill wins over invalid, and invalid wins over modified. The winner sets both the code and the vector.
- R12: In a cycle with no strobe, the captured registers (badvaddr_o, entryhi_o, context_o, exccode_o, epc_o, redirect_pc_o) keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refill_i | input | 1 | Refill fault strobe |
| invalid_i | input | 1 | Invalid entry fault strobe |
| modified_i | input | 1 | Store to clean page fault strobe |
| store_i | input | 1 | Faulting access is a store |
| fault_va_i | input | 32 | Faulting virtual address |
| asid_i | input | 8 | Current address-space identifier |
| exl_i | input | 1 | Status exception-level bit before the fault |
| ebase_i | input | 32 | Exception base address |
| pc_i | input | 32 | PC of the faulting instruction |
| badvaddr_o | output | 32 | Fault address register |
| entryhi_o | output | 32 | Translation high register |
| context_o | output | 32 | Page-table context register (bad page field only) |
| exccode_o | output | 5 | Cause exception code |
| epc_o | output | 32 | Exception return PC |
| exl_o | output | 1 | Updated exception-level bit |
| redirect_valid_o | output | 1 | One-cycle handler redirect strobe |
| redirect_pc_o | output | 32 | Handler address |

## Verification
The assertions assume that the fault strobes are never high in two consecutive cycles. That is the one-cycle strobe contract, and the single-pulse check on the redirect relies on it. They also assume the inputs are stable at a known value while reset is applied. The bench meets both assumptions by driving every fault for one cycle and following it with at least one idle cycle. It holds all inputs at zero during reset. Its random part draws all eight strobe combinations, including none and all three, with random exception-level and store values.

// File: rtl/tlb_exc_entry.sv
module tlb_exc_entry #(
  parameter int AW        = 32,
  parameter int ASID_W    = 8,
  parameter int VPN_LSB   = 13,
  parameter int CTX_LSB   = 4,
  parameter int CODE_W    = 5,
  parameter logic [AW-1:0] GEN_OFS = 'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refill_i,
  input  logic              invalid_i,
  input  logic              modified_i,
  input  logic              store_i,
  input  logic [AW-1:0]     fault_va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              exl_i,
  input  logic [AW-1:0]     ebase_i,
  input  logic [AW-1:0]     pc_i,
  output logic [AW-1:0]     badvaddr_o,
  output logic [AW-1:0]     entryhi_o,
  output logic [AW-1:0]     context_o,
  output logic [CODE_W-1:0] exccode_o,
  output logic [AW-1:0]     epc_o,
  output logic              exl_o,
  output logic              redirect_valid_o,
  output logic [AW-1:0]     redirect_pc_o
);

  localparam int VPN_W   = AW - VPN_LSB;
  localparam int EH_GAP  = VPN_LSB - ASID_W;
  localparam int CTX_TOP = AW - CTX_LSB - VPN_W;
  localparam logic [CODE_W-1:0] CODE_MOD   = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_LOAD  = CODE_W'(2);
  localparam logic [CODE_W-1:0] CODE_STORE = CODE_W'(3);

  logic              fault_any, pick_refill, pick_mod;
  logic [CODE_W-1:0] code_nxt;
  logic [AW-1:0]     vec_nxt;
  logic [VPN_W-1:0]  vpn2;

  assign fault_any   = refill_i | invalid_i | modified_i;
  assign pick_refill = refill_i;
  assign pick_mod    = modified_i & ~refill_i & ~invalid_i;
  assign vpn2        = fault_va_i[AW-1:VPN_LSB];
  assign code_nxt    = pick_mod ? CODE_MOD : (store_i ? CODE_STORE : CODE_LOAD);
  assign vec_nxt     = (pick_refill && !exl_i) ? ebase_i : ebase_i + GEN_OFS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      badvaddr_o       <= '0;
      entryhi_o        <= '0;
      context_o        <= '0;
      exccode_o        <= '0;
      epc_o            <= '0;
      exl_o            <= 1'b0;
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
    end else begin
      redirect_valid_o <= fault_any;
      exl_o            <= fault_any | exl_i;
      if (fault_any) begin
        badvaddr_o    <= fault_va_i;
        entryhi_o     <= {vpn2, {EH_GAP{1'b0}}, asid_i};
        context_o     <= {{CTX_TOP{1'b0}}, vpn2, {CTX_LSB{1'b0}}};
        exccode_o     <= code_nxt;
        redirect_pc_o <= vec_nxt;
        if (!exl_i) epc_o <= pc_i;
      end
    end
  end

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> redirect_valid_o);
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |=> !redirect_valid_o);
  a_r10_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> exl_o);
  a_r2_badva: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> badvaddr_o == $past(fault_va_i));
  a_r7_fast_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_i && !exl_i) |=> redirect_pc_o == $past(ebase_i));
  a_r6_mod_code: assert property (@(posedge clk) disable iff (!rst_n)
    (modified_i && !refill_i && !invalid_i) |=> exccode_o == CODE_MOD);
  a_r9_epc_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && exl_i) |=> $stable(epc_o));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_any |=> ($stable(badvaddr_o) && $stable(entryhi_o) && $stable(context_o)
                    && $stable(exccode_o) && $stable(redirect_pc_o)));

endmodule

// File: tb/tlb_exc_entry_tb.sv
`timescale 1ns/1ps
module tlb_exc_entry_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic refill_i = 0, invalid_i = 0, modified_i = 0, store_i = 0, exl_i = 0;
  logic [31:0] fault_va_i = '0, ebase_i = '0, pc_i = '0;
  logic [7:0]  asid_i = '0;
  logic [31:0] badvaddr_o, entryhi_o, context_o, epc_o, redirect_pc_o;
  logic [4:0]  exccode_o;
  logic        exl_o, redirect_valid_o;

  int checks = 0, fails = 0;
  logic [31:0] e_bva = 0, e_ehi = 0, e_ctx = 0, e_epc = 0, e_pc = 0;
  logic [4:0]  e_code = 0;

  always #2.5 clk = ~clk;

  tlb_exc_entry u_dut (
    .clk(clk), .rst_n(rst_n), .refill_i(refill_i), .invalid_i(invalid_i),
    .modified_i(modified_i), .store_i(store_i), .fault_va_i(fault_va_i),
    .asid_i(asid_i), .exl_i(exl_i), .ebase_i(ebase_i), .pc_i(pc_i),
    .badvaddr_o(badvaddr_o), .entryhi_o(entryhi_o), .context_o(context_o),
    .exccode_o(exccode_o), .epc_o(epc_o), .exl_o(exl_o),
    .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_code(input logic [2:0] m, input logic st);
    if (m[0] || m[1]) return st ? 5'd3 : 5'd2;
    return 5'd1;
  endfunction

  function automatic logic [31:0] ref_vec(input logic [2:0] m, input logic ex, input logic [31:0] eb);
    if (m[0] && !ex) return eb;
    return eb + 32'h180;
  endfunction

  task automatic apply(input logic [2:0] m, input logic st, input logic [31:0] va,
                       input logic [7:0] asid, input logic ex, input logic [31:0] eb,
                       input logic [31:0] pc);
    string creq, vreq;
    @(negedge clk);
    refill_i = m[0]; invalid_i = m[1]; modified_i = m[2];
    store_i = st; fault_va_i = va; asid_i = asid; exl_i = ex; ebase_i = eb; pc_i = pc;
    if (m != 3'b000) begin
      e_bva  = va;
      e_ehi  = {va[31:13], 5'b0, asid};
      e_ctx  = {9'b0, va[31:13], 4'b0};
      e_code = ref_code(m, st);
      e_pc   = ref_vec(m, ex, eb);
      if (!ex) e_epc = pc;
    end
    @(posedge clk);
    @(negedge clk);
    creq = ($countones(m) > 1) ? "R11 code" : (m[0] || m[1]) ? "R5 code" : "R6 code";
    vreq = ($countones(m) > 1) ? "R11 vector" : m[0] ? "R7 vector" : "R8 vector";
    if (m != 3'b000) begin
      chk(redirect_valid_o === 1'b1, "R10 redirect valid", 32'(redirect_valid_o), 1);
      chk(exl_o === 1'b1, "R10 exl set", 32'(exl_o), 1);
      chk(badvaddr_o === e_bva, "R2 badvaddr", badvaddr_o, e_bva);
      chk(entryhi_o === e_ehi, "R3 entryhi", entryhi_o, e_ehi);
      chk(context_o === e_ctx, "R4 context", context_o, e_ctx);
      chk(exccode_o === e_code, creq, 32'(exccode_o), 32'(e_code));
      chk(redirect_pc_o === e_pc, vreq, redirect_pc_o, e_pc);
      chk(epc_o === e_epc, "R9 epc", epc_o, e_epc);
    end else begin
      chk(redirect_valid_o === 1'b0, "R10 no redirect", 32'(redirect_valid_o), 0);
      chk(exl_o === ex, "R10 exl follows", 32'(exl_o), 32'(ex));
    end
    refill_i = 0; invalid_i = 0; modified_i = 0;
    fault_va_i = ~va; asid_i = ~asid; pc_i = ~pc; ebase_i = ~eb; store_i = ~st;
    @(posedge clk);
    @(negedge clk);
    chk(redirect_valid_o === 1'b0, "R10 single pulse", 32'(redirect_valid_o), 0);
    chk(exl_o === ex, "R10 exl follows input", 32'(exl_o), 32'(ex));
    chk(badvaddr_o === e_bva && entryhi_o === e_ehi && context_o === e_ctx,
        "R12 hold addr regs", badvaddr_o, e_bva);
    chk(exccode_o === e_code && epc_o === e_epc && redirect_pc_o === e_pc,
        "R12 hold cause/pc", redirect_pc_o, e_pc);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(redirect_valid_o === 1'b0 && exl_o === 1'b0, "R1 reset flags", 32'(redirect_valid_o), 0);
    chk(badvaddr_o === 0 && entryhi_o === 0 && context_o === 0 && epc_o === 0 &&
        exccode_o === 0 && redirect_pc_o === 0, "R1 reset regs", badvaddr_o, 0);
    rst_n = 1'b1;
    // directed corners
    apply(3'b001, 0, 32'hDEAD_BEEF, 8'h5A, 0, 32'h8000_0000, 32'h0040_1000); // R7 fast vector, R5 load
    apply(3'b001, 1, 32'h1234_5678, 8'hA5, 1, 32'h8000_0000, 32'h0040_2000); // R7 general, R9 keep
    apply(3'b010, 1, 32'hFFFF_E000, 8'hFF, 0, 32'h9000_1000, 32'h0040_3000); // R8, R5 store
    apply(3'b010, 0, 32'h0000_1FFF, 8'h00, 1, 32'h9000_1000, 32'h0040_4000);
    apply(3'b100, 0, 32'hCAFE_0000, 8'h11, 0, 32'hA000_0000, 32'h0040_5000); // R6 store flag 0
    apply(3'b100, 1, 32'hCAFE_2000, 8'h22, 1, 32'hA000_0000, 32'h0040_6000); // R6 store flag 1
    apply(3'b111, 0, 32'h7000_3000, 8'h33, 0, 32'hB000_0000, 32'h0040_7000); // R11
    apply(3'b101, 1, 32'h6000_4000, 8'h44, 0, 32'hB000_0000, 32'h0040_8000); // R11
    apply(3'b110, 0, 32'h5000_5000, 8'h55, 0, 32'hB000_0000, 32'h0040_9000); // R11 invalid over modified
    apply(3'b000, 1, 32'h4000_6000, 8'h66, 1, 32'hC000_0000, 32'h0040_A000); // R12 no fault
    for (int k = 0; k < 300; k++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      apply(m, 1'($urandom), $urandom, 8'($urandom), 1'($urandom), $urandom, $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule